// File: doc/BRIEF.md
# VPW Frame Structure Checker

This block takes the symbol stream of a variable-pulse-width serial vehicle bus after pulse-width decoding and turns it into checked frame content. Each clock cycle carries at most one symbol event: start of frame, a data bit with its value, end of data, normalization bit or end of frame. The block shifts data bits into bytes with the most significant bit first and follows the frame phase. It emits every byte it receives with a kind tag, an index and a one-cycle valid strobe, a one-cycle done pulse at the end of a complete frame, and one-cycle error pulses for length, framing and CRC problems.

A message holds at most twelve bytes, counted between start of frame and end of data. The first byte is the priority byte and the second is the message identifier (both tagged as header). Any further bytes are data, and the last byte before end of data is the CRC. After end of data, a normalization bit may open an in-frame response, whose bytes are passed on tagged as response bytes. End of frame closes the frame. A message byte cannot be classified until the next symbol arrives, so each message byte is held back by one byte slot.

Top module: `vpw_frame_checker`

## Requirements
- R1: Data bits are assembled into bytes most significant bit first. The first bit received after start of frame (or after the normalization bit) becomes bit 7 of the byte.
- R2: Each output byte carries `byte_kind`: 0 = header (message index 0 or 1), 1 = data (message index 2 to 11), 2 = CRC (the last message byte before end of data), 3 = in-frame response. `byte_index` is the position counted from 0 within the message, or within the response for kind 3.
- R3: A message byte is emitted one cycle after the symbol that follows it: either the eighth bit of the next byte or end of data. A response byte is emitted one cycle after its own eighth bit.
- R4: At end of data, a CRC-8 (polynomial 0x1D, initial value 0xFF) run over all message bytes including the CRC byte must leave 0xC4. If it does not, `err_crc` pulses in the same cycle as the CRC byte.
- R5: If a thirteenth message byte completes, `err_length` pulses one cycle later. The held byte and the thirteenth byte are discarded, and the frame is abandoned.
- R6: End of data that arrives with a partial byte, or with no byte at all, raises `err_framing` one cycle later. The partial byte is discarded and the frame is abandoned.
- R7: Start of frame inside an active frame raises `err_framing` one cycle later and begins a new frame.
- R8: While no frame is active, every symbol other than start of frame is ignored and produces no output.
- R9: End of frame directly after end of data, or after a non-empty, byte-aligned in-frame response, gives a `frame_done` pulse one cycle later. A normalization bit after end of data opens the response.
- R10: A symbol out of order raises `err_framing` one cycle later and abandons the frame. This covers end of frame or a normalization bit before end of data, a data bit or end of data between end of data and the next symbol, and end of data, a normalization bit, or an empty or misaligned end of frame within the response.
- R11: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_sof | input | 1 | Start-of-frame symbol event (wins over any other event in the same cycle) |
| sym_bit | input | 1 | Data-bit symbol event |
| sym_bit_val | input | 1 | Value of the data bit |
| sym_eod | input | 1 | End-of-data symbol event |
| sym_nb | input | 1 | Normalization-bit symbol event |
| sym_eof | input | 1 | End-of-frame symbol event |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_kind | output | 2 | 0 header, 1 data, 2 CRC, 3 response |
| byte_index | output | 4 | Byte position within message or response |
| frame_done | output | 1 | One-cycle pulse at a complete frame |
| err_length | output | 1 | One-cycle pulse at a message-length violation |
| err_framing | output | 1 | One-cycle pulse at a symbol-order or alignment violation |
| err_crc | output | 1 | One-cycle pulse when the CRC residue is wrong |

## Verification
The main path is driven with frames of one, four and twelve bytes, so that the header, data and CRC tags and the one-slot hold-back are each seen in the first, middle and last position of a message. A frame with a corrupted CRC byte is sent next to a frame with a correct one, which separates the residue check from the byte path. A frame with a response after a normalization bit separates response indexing from message indexing. Over-long frames, misaligned end of data, start of frame in the middle of a frame, missing end of data, and bits sent while idle each show whether the block abandons or ignores, and whether anything leaks out before the next start of frame.

// File: rtl/vpw_pkg.sv
// Package: shared types and constants for the VPW frame checker.
// Assumes an 8-bit byte and an 8-bit CRC.
package vpw_pkg;
    typedef enum logic [1:0] {
        KIND_HDR  = 2'd0,
        KIND_DATA = 2'd1,
        KIND_CRC  = 2'd2,
        KIND_IFR  = 2'd3
    } byte_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MSG,
        PH_POST,
        PH_IFR
    } phase_t;

    localparam int unsigned BYTE_W      = 8;
    localparam logic [7:0]  CRC_POLY    = 8'h1D;
    localparam logic [7:0]  CRC_INIT    = 8'hFF;
    localparam logic [7:0]  CRC_RESIDUE = 8'hC4;
endpackage

// File: rtl/vpw_bit_shifter.sv
// Module: collects serial bits into words, first bit in the MSB position.
// Assumes at most one shift per cycle; clear wins over shift.
module vpw_bit_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         word_done,
    output logic         aligned
);
    localparam int unsigned PW = $clog2(W);
    localparam logic [PW-1:0] LAST = PW'(W - 1);

    logic [W-2:0]  acc;
    logic [PW-1:0] pos;

    // Purpose: shift bits in and count the position within the word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
            pos <= '0;
        end else if (shift_en) begin
            acc <= {acc[W-3:0], bit_in};
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    // Purpose: present the finished word in the cycle of its last bit.
    always_comb begin
        word      = {acc, bit_in};
        word_done = shift_en && (pos == LAST);
        aligned   = (pos == '0);
    end
endmodule

// File: rtl/vpw_crc_acc.sv
// Module: bitwise running CRC, MSB-first, with no final inversion applied.
// Assumes the caller compares the register against the residue.
module vpw_crc_acc #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D,
    parameter logic [W-1:0] INIT = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] nxt;

    // Purpose: next CRC value for one incoming bit.
    always_comb begin
        fb  = crc[W-1] ^ bit_in;
        nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Purpose: hold the running CRC; clear reloads the initial value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= INIT;
        else if (en)         crc <= nxt;
    end
endmodule

// File: rtl/vpw_frame_checker.sv
// Module: checks the structure of received VPW frames from decoded symbols
// and emits tagged bytes, a frame-done pulse and error pulses.
// Assumes at most one symbol per cycle; start of frame has priority.
// Each message byte is held one slot until its kind (CRC or not) is known.
module vpw_frame_checker #(
    parameter int unsigned MAX_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_sof,
    input  logic       sym_bit,
    input  logic       sym_bit_val,
    input  logic       sym_eod,
    input  logic       sym_nb,
    input  logic       sym_eof,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic [1:0] byte_kind,
    output logic [3:0] byte_index,
    output logic       frame_done,
    output logic       err_length,
    output logic       err_framing,
    output logic       err_crc
);
    import vpw_pkg::*;

    localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

    phase_t              phase;
    logic [CNT_W-1:0]    msg_cnt;
    logic [CNT_W-1:0]    ifr_cnt;
    logic [BYTE_W-1:0]   pend;
    logic                is_sof, is_bit, is_eod, is_nb, is_eof;
    logic                sh_clear, sh_en, sh_done, sh_aligned;
    logic [BYTE_W-1:0]   sh_word;
    logic                crc_en;
    logic [BYTE_W-1:0]   crc_val;

    // Purpose: decode one symbol per cycle with start of frame first.
    always_comb begin
        is_sof = sym_sof;
        is_bit = !sym_sof && sym_bit;
        is_eod = !sym_sof && !sym_bit && sym_eod;
        is_nb  = !sym_sof && !sym_bit && !sym_eod && sym_nb;
        is_eof = !sym_sof && !sym_bit && !sym_eod && !sym_nb && sym_eof;
        sh_en    = is_bit && (phase == PH_MSG || phase == PH_IFR);
        sh_clear = is_sof || (is_nb && phase == PH_POST);
        crc_en   = is_bit && (phase == PH_MSG);
    end

    vpw_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift_en(sh_en),
        .bit_in(sym_bit_val), .word(sh_word), .word_done(sh_done),
        .aligned(sh_aligned)
    );

    vpw_crc_acc #(.W(BYTE_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(is_sof), .en(crc_en),
        .bit_in(sym_bit_val), .crc(crc_val)
    );

    // Purpose: frame phase, byte hold-back and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            msg_cnt     <= '0;
            ifr_cnt     <= '0;
            pend        <= '0;
            byte_valid  <= 1'b0;
            byte_data   <= '0;
            byte_kind   <= '0;
            byte_index  <= '0;
            frame_done  <= 1'b0;
            err_length  <= 1'b0;
            err_framing <= 1'b0;
            err_crc     <= 1'b0;
        end else begin
            byte_valid  <= 1'b0;
            frame_done  <= 1'b0;
            err_length  <= 1'b0;
            err_framing <= 1'b0;
            err_crc     <= 1'b0;
            if (is_sof) begin
                err_framing <= (phase != PH_IDLE);
                phase       <= PH_MSG;
                msg_cnt     <= '0;
            end else begin
                unique case (phase)
                    PH_MSG: begin
                        if (is_bit && sh_done) begin
                            if (msg_cnt == CNT_MAX) begin
                                err_length <= 1'b1;
                                phase      <= PH_IDLE;
                            end else begin
                                if (msg_cnt != '0) begin
                                    byte_valid <= 1'b1;
                                    byte_data  <= pend;
                                    byte_kind  <= (msg_cnt <= CNT_W'(2)) ? KIND_HDR : KIND_DATA;
                                    byte_index <= 4'(msg_cnt - 1'b1);
                                end
                                pend    <= sh_word;
                                msg_cnt <= msg_cnt + 1'b1;
                            end
                        end else if (is_eod) begin
                            if (!sh_aligned || msg_cnt == '0) begin
                                err_framing <= 1'b1;
                                phase       <= PH_IDLE;
                            end else begin
                                byte_valid <= 1'b1;
                                byte_data  <= pend;
                                byte_kind  <= KIND_CRC;
                                byte_index <= 4'(msg_cnt - 1'b1);
                                err_crc    <= (crc_val != CRC_RESIDUE);
                                phase      <= PH_POST;
                            end
                        end else if (is_nb || is_eof) begin
                            err_framing <= 1'b1;
                            phase       <= PH_IDLE;
                        end
                    end
                    PH_POST: begin
                        if (is_nb) begin
                            phase   <= PH_IFR;
                            ifr_cnt <= '0;
                        end else if (is_eof) begin
                            frame_done <= 1'b1;
                            phase      <= PH_IDLE;
                        end else if (is_bit || is_eod) begin
                            err_framing <= 1'b1;
                            phase       <= PH_IDLE;
                        end
                    end
                    PH_IFR: begin
                        if (is_bit && sh_done) begin
                            byte_valid <= 1'b1;
                            byte_data  <= sh_word;
                            byte_kind  <= KIND_IFR;
                            byte_index <= 4'(ifr_cnt);
                            ifr_cnt    <= ifr_cnt + 1'b1;
                        end else if (is_eof) begin
                            frame_done  <= sh_aligned && (ifr_cnt != '0);
                            err_framing <= !(sh_aligned && (ifr_cnt != '0));
                            phase       <= PH_IDLE;
                        end else if (is_eod || is_nb) begin
                            err_framing <= 1'b1;
                            phase       <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: header bytes sit only at message positions 0 and 1
    a_r2_header_index: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_kind == KIND_HDR |-> byte_index < 4'd2);

    // R2: data bytes sit between position 2 and the message limit
    a_r2_data_index: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_kind == KIND_DATA |->
            byte_index >= 4'd2 && 32'(byte_index) < MAX_BYTES);

    // R3: a CRC-tagged byte only follows an end-of-data symbol
    a_r3_crc_after_eod: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_kind == KIND_CRC |-> $past(sym_eod));

    // R9: frame completion only follows an end-of-frame symbol
    a_r9_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(sym_eof) && !byte_valid);

    // R5: a length violation never comes with a byte or completion
    a_r5_len_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        err_length |-> !byte_valid && !frame_done && !err_framing);

    // R11: outputs are low in the cycle after a reset cycle
    a_r11_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) && !$isunknown($past(rst_n)) |->
            !byte_valid && !frame_done && !err_length && !err_framing && !err_crc);
endmodule

// File: tb/sim_vpw_frame_checker.sv
module sim_vpw_frame_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_sof = 0, sym_bit = 0, sym_bit_val = 0, sym_eod = 0, sym_nb = 0, sym_eof = 0;
    logic       byte_valid, frame_done, err_length, err_framing, err_crc;
    logic [7:0] byte_data;
    logic [1:0] byte_kind;
    logic [3:0] byte_index;

    always #2 clk = ~clk;

    vpw_frame_checker u0 (
        .clk(clk), .rst_n(rst_n), .sym_sof(sym_sof), .sym_bit(sym_bit),
        .sym_bit_val(sym_bit_val), .sym_eod(sym_eod), .sym_nb(sym_nb),
        .sym_eof(sym_eof), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_kind(byte_kind), .byte_index(byte_index), .frame_done(frame_done),
        .err_length(err_length), .err_framing(err_framing), .err_crc(err_crc)
    );

    // Expected events: 0 byte, 1 done, 2 length, 3 framing, 4 crc
    typedef struct {
        int    ev;
        int    kind;
        int    idx;
        int    data;
        string req;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    int unexp = 0;

    // Bench-side frame model: 0 idle, 1 message, 2 after EOD, 3 response
    int         ph = 0;
    int         msg_n = 0;
    int         ifr_n = 0;
    logic [7:0] prev_b = 0;
    logic [7:0] bcrc = 8'hFF;

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
        end
        return c;
    endfunction

    task automatic push(input int ev, input int kind, input int idx, input int data, input string req);
        exp_t e;
        e.ev = ev; e.kind = kind; e.idx = idx; e.data = data; e.req = req;
        q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare each output pulse with the head of the queue
    task automatic take(input int ev, input int kind, input int idx, input int data);
        exp_t e;
        if (q.size() == 0) begin
            unexp++;
            total++;
            bad++;
            $display("FAIL R3 unexpected event actual=%0d expected=none", ev);
        end else begin
            e = q.pop_front();
            check(e.ev == ev && e.kind == kind && e.idx == idx && e.data == data,
                  e.req, (ev << 24) | (kind << 16) | (idx << 8) | data,
                  (e.ev << 24) | (e.kind << 16) | (e.idx << 8) | e.data);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid)  take(0, int'(byte_kind), int'(byte_index), int'(byte_data));
            if (err_crc)     take(4, 0, 0, 0);
            if (frame_done)  take(1, 0, 0, 0);
            if (err_length)  take(2, 0, 0, 0);
            if (err_framing) take(3, 0, 0, 0);
        end
    end

    task automatic drive(input logic s, input logic b, input logic v, input logic e,
                         input logic n, input logic f);
        @(negedge clk);
        sym_sof = s; sym_bit = b; sym_bit_val = v; sym_eod = e; sym_nb = n; sym_eof = f;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_sof();
        if (ph != 0) push(3, 0, 0, 0, "R7 sof mid-frame");
        drive(1, 0, 0, 0, 0, 0);
        ph = 1; msg_n = 0; bcrc = 8'hFF;
    endtask

    task automatic t_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) begin
                if (ph == 1) begin
                    if (msg_n == 12) begin
                        push(2, 0, 0, 0, "R5 length");
                        ph = 0;
                    end else if (msg_n > 0) begin
                        push(0, (msg_n <= 2) ? 0 : 1, msg_n - 1, int'(prev_b), "R1/R2/R3 message byte");
                    end
                end else if (ph == 3) begin
                    push(0, 3, ifr_n, int'(b), "R2/R3 response byte");
                end
            end
            drive(0, 1, b[i], 0, 0, 0);
        end
        if (ph == 1) begin
            prev_b = b; msg_n++; bcrc = crc_byte(bcrc, b);
        end else if (ph == 3) begin
            ifr_n++;
        end
    endtask

    task automatic t_eod();
        if (ph == 1) begin
            if (msg_n == 0) begin
                push(3, 0, 0, 0, "R6 empty eod");
                ph = 0;
            end else begin
                push(0, 2, msg_n - 1, int'(prev_b), "R2 crc byte");
                if (bcrc != 8'hC4) push(4, 0, 0, 0, "R4 crc residue");
                ph = 2;
            end
        end
        drive(0, 0, 0, 1, 0, 0);
    endtask

    task automatic t_nb();
        if (ph == 2) begin
            ph = 3; ifr_n = 0;
        end
        drive(0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_eof();
        if (ph == 2 || (ph == 3 && ifr_n > 0)) push(1, 0, 0, 0, "R9 frame done");
        else if (ph != 0) push(3, 0, 0, 0, "R10 eof order");
        ph = 0;
        drive(0, 0, 0, 0, 0, 1);
    endtask

    task automatic send_msg(input int n, input int seed, input bit corrupt);
        logic [7:0] c;
        logic [7:0] b;
        c = 8'hFF;
        t_sof();
        for (int i = 0; i < n - 1; i++) begin
            b = 8'(seed * 37 + i * 91 + 5);
            c = crc_byte(c, b);
            t_byte(b);
        end
        c = ~c;
        if (corrupt) c = c ^ 8'h01;
        t_byte(c);
        t_eod();
    endtask

    task automatic settle(input string req);
        idle(3);
        check(q.size() == 0, req, q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs quiet in reset
        check({byte_valid, frame_done, err_length, err_framing, err_crc} == 5'b0,
              "R11 reset", {byte_valid, frame_done, err_length, err_framing, err_crc}, 0);
        rst_n = 1'b1;
        idle(2);

        // R8: bits and symbols while idle are ignored
        t_byte(8'hA5); t_eod(); t_nb(); t_eof();
        settle("R8 idle queue");
        check(unexp == 0, "R8 idle output", unexp, 0);

        // R1 R2 R4 R9: four-byte good frame
        send_msg(4, 1, 0); t_eof(); settle("R9 four byte frame");

        // R4: corrupted CRC byte
        send_msg(4, 2, 1); t_eof(); settle("R4 bad crc frame");

        // R2: single-byte frame is tagged CRC at index 0
        send_msg(1, 3, 0); t_eof(); settle("R2 one byte frame");

        // R2 R3: twelve-byte frame, the limit
        send_msg(12, 4, 0); t_eof(); settle("R3 twelve byte frame");

        // R5: thirteen bytes
        t_sof();
        for (int i = 0; i < 13; i++) t_byte(8'(i * 29 + 1));
        t_eod(); t_eof();
        settle("R5 long frame");

        // R6: partial byte at end of data
        t_sof(); t_byte(8'h3C);
        for (int i = 0; i < 3; i++) drive(0, 1, 1, 0, 0, 0);
        push(3, 0, 0, 0, "R6 misaligned eod");
        drive(0, 0, 0, 1, 0, 0);
        ph = 0;
        t_eof();
        settle("R6 misaligned");

        // R6: end of data with no byte
        t_sof(); t_eod(); settle("R6 empty");

        // R7: restart in mid-frame, then a clean frame
        t_sof(); t_byte(8'h11); t_byte(8'h22);
        send_msg(3, 5, 0); t_eof(); settle("R7 restart");

        // R9 R2: frame with in-frame response
        send_msg(3, 6, 0); t_nb(); t_byte(8'hC3); t_byte(8'h5A); t_eof();
        settle("R9 response frame");

        // R10: end of frame without end of data
        t_sof(); t_byte(8'h77); t_eof(); settle("R10 missing eod");

        // R10: empty response then end of frame
        send_msg(2, 7, 0); t_nb(); t_eof(); settle("R10 empty response");

        // R10: data bit right after end of data
        send_msg(2, 8, 0);
        push(3, 0, 0, 0, "R10 bit after eod");
        drive(0, 1, 1, 0, 0, 0);
        ph = 0;
        settle("R10 bit after eod");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule